// File: doc/BRIEF.md
# Speculative Return-Address Predictor

This block predicts where return instructions will jump. It keeps a small circular store of return addresses. A call request writes the address that follows the call, which is the call PC plus a fixed instruction size, into the slot above the current top. A return request reads the top slot during the same cycle and drives it out as the predicted target, together with a valid flag. When too many calls nest, the newest address overwrites the oldest one. When the store is empty, a return gets no prediction and never a stale address.

An occupancy state machine tracks the fill level. It has three states. `OCC_EMPTY` means the count is zero. `OCC_PARTIAL` means the count is between one and DEPTH-1. `OCC_FULL` means the count equals DEPTH. The transitions are:
- PUSH_FIRST: `OCC_EMPTY` to `OCC_PARTIAL`.
- PUSH_GROW: stays in `OCC_PARTIAL`.
- PUSH_FILL: `OCC_PARTIAL` to `OCC_FULL`.
- PUSH_EVICT: stays in `OCC_FULL`.
- POP_SHRINK: stays in `OCC_PARTIAL`.
- POP_LAST: `OCC_PARTIAL` to `OCC_EMPTY`.
- POP_FROM_FULL: `OCC_FULL` to `OCC_PARTIAL`.
- POP_IDLE: an empty pop, stays in `OCC_EMPTY`.
- RESTORE_LOAD: from any state to the state that matches the loaded count.

For speculative recovery, the top-of-stack pointer and the count are always visible as one checkpoint word. The fetch logic stores this word next to each branch. After a misprediction flush, it writes the word back through the restore port. Restore wins over a call or return that arrives in the same cycle.

Top module: `ras_predictor`

## Requirements
- R1: A call at PC p writes p + INSN_BYTES (default 4). From the next cycle, that value is the top entry, with pred_valid high.
- R2: A call advances the pointer by one, modulo DEPTH. It raises the count by one, saturating at DEPTH.
- R3: A return while the count is nonzero drives pred_valid high and pred_target equal to the top entry in the same cycle. On the clock edge, the pointer moves back by one modulo DEPTH and the count drops by one. call_req and ret_req are never asserted together.
- R4: A call while the count equals DEPTH overwrites the oldest entry, and the count stays at DEPTH. With DEPTH=4, five calls followed by five returns give the last four addresses in reverse order, then no prediction.
- R5: While the count is zero, pred_valid is low. A return in that state leaves the pointer and the count unchanged.
- R6: ckpt_out is {pointer, count}. The pointer takes the upper log2(DEPTH) bits and the count takes the lower log2(DEPTH)+1 bits.
- R7: When restore_req is high, ckpt_out takes the value of restore_ckpt on the next cycle, with a count above DEPTH clamped to DEPTH. Later returns predict the entries that lay below the restored top.
- R8: Synchronous reset clears the pointer, the count and every valid bit. ckpt_out then reads 0 and pred_valid reads 0.
- R9: A call at 0x1000, then a call at 0x2000, then two returns predict 0x2004 and then 0x1004, leaving the count at 0.
- R10: If restore_req is high together with call_req or ret_req, the call or return is discarded and only the restore takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| call_req | input | 1 | A call is being predicted this cycle |
| call_pc | input | ADDR_W | PC of the call instruction |
| ret_req | input | 1 | A return is being predicted this cycle |
| restore_req | input | 1 | Reload the pointer and count after a flush |
| restore_ckpt | input | 2*log2(DEPTH)+1 | Checkpoint word to reload |
| pred_valid | output | 1 | pred_target holds a live return address |
| pred_target | output | ADDR_W | Predicted return target (the top entry) |
| ckpt_out | output | 2*log2(DEPTH)+1 | Current {pointer, count} for checkpointing |

## Verification
A wrong pointer shows up at the next return as a wrong pred_target. It also shows up at once in ckpt_out, one cycle after the faulty update. A count that is off by one, or a state that disagrees with the count, shows first at the edges of the range. An empty store would then raise pred_valid. A full store would lose its saturation, so the count in ckpt_out would pass DEPTH or an evicted slot would be reported as valid. The scoreboard compares every return prediction against an independent stack model. It also checks the checkpoint word after each step, so most faults appear within one or two cycles of the operation that caused them.

// File: rtl/ras_pkg.sv
package ras_pkg;

    // Occupancy class of the return-address store
    typedef enum logic [1:0] {
        OCC_EMPTY   = 2'd0,
        OCC_PARTIAL = 2'd1,
        OCC_FULL    = 2'd2
    } occ_state_e;

    // Operation chosen for this cycle after priority resolution
    typedef enum logic [1:0] {
        OP_IDLE    = 2'd0,
        OP_PUSH    = 2'd1,
        OP_POP     = 2'd2,
        OP_RESTORE = 2'd3
    } ras_op_e;

endpackage

// File: rtl/ras_op_decode.sv
module ras_op_decode
    import ras_pkg::*;
(
    input  logic    call_req,
    input  logic    ret_req,
    input  logic    restore_req,
    output ras_op_e op
);

    // Restore outranks call and return; call and return are exclusive
    always_comb begin
        if (restore_req) begin
            op = OP_RESTORE;
        end else if (call_req) begin
            op = OP_PUSH;
        end else if (ret_req) begin
            op = OP_POP;
        end else begin
            op = OP_IDLE;
        end
    end

endmodule

// File: rtl/ras_occupancy.sv
module ras_occupancy
    import ras_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic                        clk,
    input  logic                        rst,
    input  ras_op_e                     op,
    input  logic [$clog2(DEPTH)-1:0]    rs_ptr,
    input  logic [$clog2(DEPTH):0]      rs_cnt,
    output logic [$clog2(DEPTH)-1:0]    tos,
    output logic [$clog2(DEPTH):0]      cnt,
    output occ_state_e                  state,
    output logic                        wr_en,
    output logic [$clog2(DEPTH)-1:0]    wr_idx,
    output logic                        has_entries
);

    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = PTR_W + 1;
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
    localparam logic [CNT_W-1:0] LAST_GAP = CNT_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] ONE_CNT  = CNT_W'(1);
    localparam logic [PTR_W-1:0] PTR_STEP = PTR_W'(1);

    occ_state_e          nxt_state;
    logic [PTR_W-1:0]    nxt_tos;
    logic [CNT_W-1:0]    nxt_cnt;
    logic [CNT_W-1:0]    rs_cnt_sat;
    occ_state_e          rs_state;

    // Clamp a restored count and classify it
    always_comb begin
        rs_cnt_sat = (rs_cnt > FULL_CNT) ? FULL_CNT : rs_cnt;
        if (rs_cnt_sat == '0) begin
            rs_state = OCC_EMPTY;
        end else if (rs_cnt_sat == FULL_CNT) begin
            rs_state = OCC_FULL;
        end else begin
            rs_state = OCC_PARTIAL;
        end
    end

    // Next-state logic
    always_comb begin
        nxt_state = state;
        nxt_tos   = tos;
        nxt_cnt   = cnt;
        if (op == OP_RESTORE) begin
            // RESTORE_LOAD
            nxt_state = rs_state;
            nxt_tos   = rs_ptr;
            nxt_cnt   = rs_cnt_sat;
        end else begin
            unique case (state)
                OCC_EMPTY: begin
                    if (op == OP_PUSH) begin
                        // PUSH_FIRST
                        nxt_tos   = tos + PTR_STEP;
                        nxt_cnt   = ONE_CNT;
                        nxt_state = (FULL_CNT == ONE_CNT) ? OCC_FULL : OCC_PARTIAL;
                    end
                    // POP_IDLE: an empty pop changes nothing
                end
                OCC_PARTIAL: begin
                    if (op == OP_PUSH) begin
                        // PUSH_GROW or PUSH_FILL
                        nxt_tos   = tos + PTR_STEP;
                        nxt_cnt   = cnt + ONE_CNT;
                        nxt_state = (cnt == LAST_GAP) ? OCC_FULL : OCC_PARTIAL;
                    end else if (op == OP_POP) begin
                        // POP_SHRINK or POP_LAST
                        nxt_tos   = tos - PTR_STEP;
                        nxt_cnt   = cnt - ONE_CNT;
                        nxt_state = (cnt == ONE_CNT) ? OCC_EMPTY : OCC_PARTIAL;
                    end
                end
                OCC_FULL: begin
                    if (op == OP_PUSH) begin
                        // PUSH_EVICT: wrap over the oldest slot, count holds
                        nxt_tos   = tos + PTR_STEP;
                        nxt_cnt   = FULL_CNT;
                        nxt_state = OCC_FULL;
                    end else if (op == OP_POP) begin
                        // POP_FROM_FULL
                        nxt_tos   = tos - PTR_STEP;
                        nxt_cnt   = cnt - ONE_CNT;
                        nxt_state = (cnt == ONE_CNT) ? OCC_EMPTY : OCC_PARTIAL;
                    end
                end
                default: begin
                    nxt_state = OCC_EMPTY;
                    nxt_cnt   = '0;
                end
            endcase
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= OCC_EMPTY;
            tos   <= '0;
            cnt   <= '0;
        end else begin
            state <= nxt_state;
            tos   <= nxt_tos;
            cnt   <= nxt_cnt;
        end
    end

    // Outputs
    always_comb begin
        wr_en       = (op == OP_PUSH);
        wr_idx      = tos + PTR_STEP;
        has_entries = (state != OCC_EMPTY);
    end

endmodule

// File: rtl/ras_entry_file.sv
module ras_entry_file #(
    parameter int DEPTH  = 16,
    parameter int ADDR_W = 48
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        wr_en,
    input  logic [$clog2(DEPTH)-1:0]    wr_idx,
    input  logic [ADDR_W-1:0]           wr_data,
    input  logic [$clog2(DEPTH)-1:0]    rd_idx,
    output logic [ADDR_W-1:0]           rd_data,
    output logic                        rd_valid
);

    localparam int PTR_W = $clog2(DEPTH);

    logic [ADDR_W-1:0] slot_addr [DEPTH];
    logic [DEPTH-1:0]  slot_live;

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        logic hit;
        assign hit = wr_en && (wr_idx == PTR_W'(g));

        always_ff @(posedge clk) begin
            if (rst) begin
                slot_live[g] <= 1'b0;
            end else if (hit) begin
                slot_live[g] <= 1'b1;
            end
        end

        always_ff @(posedge clk) begin
            if (hit) begin
                slot_addr[g] <= wr_data;
            end
        end
    end

    always_comb begin
        rd_data  = slot_addr[rd_idx];
        rd_valid = slot_live[rd_idx];
    end

endmodule

// File: rtl/ras_predictor.sv
module ras_predictor
    import ras_pkg::*;
#(
    parameter int DEPTH      = 16,
    parameter int ADDR_W     = 48,
    parameter int INSN_BYTES = 4
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            call_req,
    input  logic [ADDR_W-1:0]               call_pc,
    input  logic                            ret_req,
    input  logic                            restore_req,
    input  logic [2*$clog2(DEPTH):0]        restore_ckpt,
    output logic                            pred_valid,
    output logic [ADDR_W-1:0]               pred_target,
    output logic [2*$clog2(DEPTH):0]        ckpt_out
);

    localparam int PTR_W  = $clog2(DEPTH);
    localparam int CNT_W  = PTR_W + 1;
    localparam int CKPT_W = PTR_W + CNT_W;

    ras_op_e            op;
    logic [PTR_W-1:0]   tos;
    logic [CNT_W-1:0]   cnt;
    occ_state_e         state;
    logic               wr_en;
    logic [PTR_W-1:0]   wr_idx;
    logic               has_entries;
    logic [ADDR_W-1:0]  push_addr;
    logic [ADDR_W-1:0]  top_addr;
    logic               top_live;

    assign push_addr = call_pc + ADDR_W'(INSN_BYTES);

    ras_op_decode u_dec (
        .call_req    (call_req),
        .ret_req     (ret_req),
        .restore_req (restore_req),
        .op          (op)
    );

    ras_occupancy #(.DEPTH(DEPTH)) u_occ (
        .clk         (clk),
        .rst         (rst),
        .op          (op),
        .rs_ptr      (restore_ckpt[CKPT_W-1:CNT_W]),
        .rs_cnt      (restore_ckpt[CNT_W-1:0]),
        .tos         (tos),
        .cnt         (cnt),
        .state       (state),
        .wr_en       (wr_en),
        .wr_idx      (wr_idx),
        .has_entries (has_entries)
    );

    ras_entry_file #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_file (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .wr_data  (push_addr),
        .rd_idx   (tos),
        .rd_data  (top_addr),
        .rd_valid (top_live)
    );

    always_comb begin
        pred_valid  = has_entries && top_live && (state != OCC_EMPTY);
        pred_target = top_addr;
        ckpt_out    = {tos, cnt};
    end

endmodule

// File: rtl/ras_predictor_chk.sv
module ras_predictor_chk #(
    parameter int DEPTH      = 16,
    parameter int ADDR_W     = 48,
    parameter int INSN_BYTES = 4
) (
    input logic                         clk,
    input logic                         rst,
    input logic                         call_req,
    input logic [ADDR_W-1:0]            call_pc,
    input logic                         ret_req,
    input logic                         restore_req,
    input logic [2*$clog2(DEPTH):0]     restore_ckpt,
    input logic                         pred_valid,
    input logic [ADDR_W-1:0]            pred_target,
    input logic [2*$clog2(DEPTH):0]     ckpt_out
);

    localparam int PTR_W  = $clog2(DEPTH);
    localparam int CNT_W  = PTR_W + 1;
    localparam int CKPT_W = PTR_W + CNT_W;
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    logic [PTR_W-1:0] c_ptr;
    logic [CNT_W-1:0] c_cnt;
    assign c_ptr = ckpt_out[CKPT_W-1:CNT_W];
    assign c_cnt = ckpt_out[CNT_W-1:0];

    AST_PUSH_TARGET: assert property (@(posedge clk) disable iff (rst)
        call_req && !restore_req |=> pred_valid && pred_target == $past(call_pc) + ADDR_W'(INSN_BYTES)); // R1
    AST_PUSH_PTR_ADV: assert property (@(posedge clk) disable iff (rst)
        call_req && !restore_req |=> c_ptr == PTR_W'($past(c_ptr) + 1'b1)); // R2
    AST_POP_STEP: assert property (@(posedge clk) disable iff (rst)
        ret_req && !restore_req && c_cnt != '0 |=> c_cnt == CNT_W'($past(c_cnt) - 1'b1) && c_ptr == PTR_W'($past(c_ptr) - 1'b1)); // R3
    AST_NO_DUAL_OP: assert property (@(posedge clk) disable iff (rst)
        !(call_req && ret_req)); // R3
    AST_FULL_HOLD: assert property (@(posedge clk) disable iff (rst)
        call_req && !restore_req && c_cnt == FULL_CNT |=> c_cnt == FULL_CNT); // R4
    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        c_cnt <= FULL_CNT); // R4
    AST_EMPTY_NOPRED: assert property (@(posedge clk) disable iff (rst)
        c_cnt == '0 |-> !pred_valid); // R5
    AST_EMPTY_POP_HOLD: assert property (@(posedge clk) disable iff (rst)
        ret_req && !restore_req && c_cnt == '0 |=> $stable(ckpt_out)); // R5
    AST_RESTORE_PTR: assert property (@(posedge clk) disable iff (rst)
        restore_req |=> c_ptr == $past(restore_ckpt[CKPT_W-1:CNT_W])); // R7 R10

endmodule

bind ras_predictor ras_predictor_chk #(
    .DEPTH(DEPTH), .ADDR_W(ADDR_W), .INSN_BYTES(INSN_BYTES)
) u_chk (
    .clk(clk), .rst(rst), .call_req(call_req), .call_pc(call_pc),
    .ret_req(ret_req), .restore_req(restore_req), .restore_ckpt(restore_ckpt),
    .pred_valid(pred_valid), .pred_target(pred_target), .ckpt_out(ckpt_out)
);

// File: tb/ras_predictor_bench.sv
`timescale 1ns/100ps
module ras_predictor_bench;

    localparam int N  = 4;
    localparam int W  = 32;
    localparam int CK = 5;

    typedef struct {
        logic         v;
        logic [W-1:0] t;
        string        req;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          call_req = 1'b0;
    logic [W-1:0]  call_pc = '0;
    logic          ret_req = 1'b0;
    logic          restore_req = 1'b0;
    logic [CK-1:0] restore_ckpt = '0;
    logic          pred_valid;
    logic [W-1:0]  pred_target;
    logic [CK-1:0] ckpt_out;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    exp_t exp_q[$];
    logic [W-1:0] mdl[$];
    int mptr = 0;
    int mcnt = 0;

    always #2.5 clk = ~clk;

    ras_predictor #(.DEPTH(N), .ADDR_W(W), .INSN_BYTES(4)) u_ras_predictor (
        .clk(clk), .rst(rst), .call_req(call_req), .call_pc(call_pc),
        .ret_req(ret_req), .restore_req(restore_req), .restore_ckpt(restore_ckpt),
        .pred_valid(pred_valid), .pred_target(pred_target), .ckpt_out(ckpt_out)
    );

    function automatic logic [CK-1:0] mck();
        return {2'(mptr), 3'(mcnt)};
    endfunction

    task automatic idle_all();
        call_req = 0; ret_req = 0; restore_req = 0;
    endtask

    task automatic do_call(input logic [W-1:0] pc);
        @(negedge clk);
        idle_all();
        call_req = 1; call_pc = pc;
        mdl.push_back(pc + 4);
        if (mdl.size() > N) void'(mdl.pop_front());
        mptr = (mptr + 1) % N;
        mcnt = (mcnt < N) ? mcnt + 1 : N;
    endtask

    task automatic do_ret(input string req);
        exp_t e;
        @(negedge clk);
        idle_all();
        e.req = req;
        if (mcnt > 0) begin
            e.v = 1; e.t = mdl.pop_back();
            mptr = (mptr + N - 1) % N;
            mcnt = mcnt - 1;
        end else begin
            e.v = 0; e.t = '0;
        end
        exp_q.push_back(e);
        ret_req = 1;
    endtask

    task automatic chk_ckpt(input logic [CK-1:0] exp, input string req);
        @(negedge clk);
        idle_all();
        #1;
        checks++;
        if (ckpt_out !== exp) begin
            failures++;
            $display("FAIL %s ckpt actual=%h expected=%h", req, ckpt_out, exp);
        end
    endtask

    task automatic chk_bit(input logic act, input logic exp, input string req);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    // Scoreboard monitor: compares every unrestored return prediction
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (ret_req && !restore_req && !rst) begin
                checks++;
                if (exp_q.size() == 0) begin
                    failures++;
                    $display("FAIL scoreboard actual=return expected=no-pending-entry");
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    if (pred_valid !== e.v || (e.v && pred_target !== e.t)) begin
                        failures++;
                        $display("FAIL %s pred actual=%b/%h expected=%b/%h",
                                 e.req, pred_valid, pred_target, e.v, e.t);
                    end
                end
            end
        end
    end

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        #(5 * 100000);
        failures++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        logic [W-1:0] saved_mdl[$];
        logic [CK-1:0] saved_ck;
        int saved_ptr, saved_cnt;

        // R8: reset state
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;
        #1;
        chk_bit(ckpt_out == '0, 1'b1, "R8 ckpt zero");
        chk_bit(pred_valid, 1'b0, "R8 pred_valid");

        // R9 nested example, R1 push value, R3 pop
        do_call(32'h1000);
        chk_ckpt(mck(), "R2 after first call");
        @(negedge clk); #1;
        chk_bit(pred_valid && pred_target == 32'h1004, 1'b1, "R1 top after call");
        do_call(32'h2000);
        do_ret("R9 first return");
        do_ret("R9 second return");
        chk_ckpt(5'b0, "R9 count zero");

        // R5 empty pop
        do_ret("R5 empty pop");
        chk_ckpt(5'b0, "R5 ckpt unchanged");
        @(negedge clk); #1;
        chk_bit(pred_valid, 1'b0, "R5 no prediction when empty");

        // R4 overflow with pointer wrap (R2)
        for (int i = 0; i < 5; i++) do_call(32'h4000 + 32'(i) * 32'h100);
        chk_ckpt({2'd1, 3'd4}, "R4 full count saturates, R2 wrap");
        for (int i = 0; i < 5; i++) do_ret("R4 overflow return");
        chk_ckpt({2'd1, 3'd0}, "R4 drained");

        // R7 restore with R10 priority over a same-cycle call
        do_call(32'h0100);
        do_call(32'h0200);
        chk_ckpt(mck(), "R6 ckpt layout");
        saved_ck = ckpt_out; saved_mdl = mdl; saved_ptr = mptr; saved_cnt = mcnt;
        do_call(32'h0300);
        do_ret("R7 wrong-path return");
        do_call(32'h0400);
        do_call(32'h0500);
        @(negedge clk);
        idle_all();
        restore_req = 1; restore_ckpt = saved_ck;
        call_req = 1; call_pc = 32'h0900;
        mdl = saved_mdl; mptr = saved_ptr; mcnt = saved_cnt;
        chk_ckpt(saved_ck, "R10 restore beats call");
        do_ret("R7 post-restore return B");
        do_ret("R7 post-restore return A");
        do_ret("R7 post-restore empty");

        // R10 restore beats a same-cycle return
        @(negedge clk);
        idle_all();
        restore_req = 1; restore_ckpt = {2'd3, 3'd2}; ret_req = 1;
        chk_ckpt({2'd3, 3'd2}, "R10 restore beats return");

        // R7 clamp of an oversized count
        @(negedge clk);
        idle_all();
        restore_req = 1; restore_ckpt = {2'd2, 3'd7};
        chk_ckpt({2'd2, 3'd4}, "R7 count clamp");

        // R8 mid-run reset
        @(negedge clk);
        idle_all(); rst = 1;
        @(negedge clk); rst = 0;
        #1;
        chk_bit(ckpt_out == '0, 1'b1, "R8 ckpt after reset");
        chk_bit(pred_valid, 1'b0, "R8 valid after reset");
        mdl.delete(); mptr = 0; mcnt = 0;
        do_ret("R8 pop after reset");
        chk_ckpt(5'b0, "R8 pop after reset holds");

        repeat (2) @(negedge clk);
        if (exp_q.size() != 0) begin
            checks++; failures++;
            $display("FAIL scoreboard actual=%0d pending expected=0", exp_q.size());
        end
        finish_run();
    end

endmodule